// File: doc/BRIEF.md
# Flash Block Write-Protect Gate

This block guards the high-voltage enable of a flash erase or program sequence. It has an 8-bit protect register on a simple register bus. The register's upper seven bits give a 512-byte-aligned start address. Every flash location from that start up to the top of the 16-bit space is locked. When the sequencer asks to raise the high-voltage enable for a target address, the gate compares the address with the locked window. It grants the request only when the address lies outside the window. A refused request leaves the enable as it was and raises a one-cycle violation flag.

Two register values have special meaning. All zeros places the start at address zero, so the whole array is locked; this is also the reset state. All ones is reserved as an unlock code: it turns protection off everywhere. The register is read and written at a single bus address. Other bus addresses read as zero. Read data appears one cycle after the read strobe.

Top module: `flash_wp_gate`

## Requirements
- R1: After synchronous reset the protect register is 0x00, `hv_en` is 0, `hv_viol` is 0 and `bus_rdata` is 0.
- R2: A write strobe with `bus_addr` equal to 0xFE09 loads all 8 bits of `bus_wdata` into the protect register at that clock edge. A read strobe at 0xFE09 returns the register value (the value held before any write in the same cycle) on `bus_rdata` in the following cycle, and bit 0 reads back as written.
- R3: A read at any other bus address, or a cycle with no read strobe, gives `bus_rdata` = 0 in the next cycle. A write at any other address leaves the register unchanged.
- R4: For a register value P other than 0xFF, the locked window starts at {P[7:1], 9'b0}. A target address is locked when it is unsigned greater than or equal to that start.
- R5: With P = 0x00 every target address, 0x0000 included, is locked.
- R6: With P = 0xFF no target address is locked, 0xFFFF included.
- R7: Apart from the 0xFF code, bit 0 of P has no effect on the decision: P and P^1 give the same result for any address.
- R8: A set request (`hv_set_req`) at an unlocked address, with no clear request, drives `hv_en` to 1 in the next cycle. `hv_en` then holds until a clear request arrives.
- R9: A set request at a locked address drives `hv_viol` to 1 for exactly the next cycle and does not raise `hv_en`. `hv_viol` is otherwise 0.
- R10: A clear request (`hv_clr_req`) drives `hv_en` to 0 in the next cycle and takes priority over a set request in the same cycle.
- R11: A register write never changes `hv_en`. The decision for a set request uses the register value held in the cycle of the request, so a new value governs requests from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data |
| op_addr | input | 16 | Target flash address of the pending operation |
| hv_set_req | input | 1 | Request to set the high-voltage enable |
| hv_clr_req | input | 1 | Request to clear the high-voltage enable |
| hv_en | output | 1 | Gated high-voltage enable |
| hv_viol | output | 1 | One-cycle pulse for a refused set request |

## Verification
The assertions assume that every input is a known value on each clock edge after reset. They also assume that each cycle with `hv_set_req` high is a separate request, not one request held across cycles. The constrained random stimulus redraws every input each cycle from a seeded generator, so inputs are never unknown. It weights the bus address toward the register address and weights the register value toward 0x00, 0xFF, 0xFE and window boundaries. This keeps the locked and unlocked outcomes, simultaneous set and clear requests, and writes during an active enable all frequent.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int unsigned FWP_ADDR_W = 16;
  localparam int unsigned FWP_DATA_W = 8;
  localparam int unsigned FWP_BLK_LSB = 9;

  // start of locked window: upper register bits become upper address bits
  function automatic logic [FWP_ADDR_W-1:0] fwp_start(input logic [FWP_DATA_W-1:0] p);
    fwp_start = {p[FWP_DATA_W-1:1], {FWP_BLK_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/fwp_protreg.sv
module fwp_protreg #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] prot_q
);
  logic hit;
  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && hit) prot_q <= bus_wdata;
      bus_rdata <= (bus_rd && hit) ? prot_q : '0;
    end
  end
endmodule

// File: rtl/fwp_range.sv
module fwp_range
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] prot_q,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              locked
);
  logic              unlock_code;
  logic [ADDR_W-1:0] start;

  assign unlock_code = &prot_q;
  assign start       = fwp_start(prot_q);
  assign locked      = !unlock_code && (op_addr >= start);
endmodule

// File: rtl/fwp_hvgate.sv
module fwp_hvgate (
  input  logic clk,
  input  logic rst,
  input  logic hv_set_req,
  input  logic hv_clr_req,
  input  logic locked,
  output logic hv_en,
  output logic hv_viol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hv_en   <= 1'b0;
      hv_viol <= 1'b0;
    end else begin
      hv_viol <= hv_set_req && locked;
      if (hv_clr_req)                hv_en <= 1'b0;
      else if (hv_set_req && !locked) hv_en <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = FWP_ADDR_W,
  parameter int unsigned DATA_W = FWP_DATA_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              hv_set_req,
  input  logic              hv_clr_req,
  output logic              hv_en,
  output logic              hv_viol
);
  logic [DATA_W-1:0] prot_q;
  logic              locked;

  fwp_protreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_q(prot_q)
  );

  fwp_range #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_range (
    .prot_q(prot_q), .op_addr(op_addr), .locked(locked)
  );

  fwp_hvgate u_gate (
    .clk(clk), .rst(rst), .hv_set_req(hv_set_req), .hv_clr_req(hv_clr_req),
    .locked(locked), .hv_en(hv_en), .hv_viol(hv_viol)
  );
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [ADDR_W-1:0] op_addr,
  input logic              hv_set_req,
  input logic              hv_clr_req,
  input logic              hv_en,
  input logic              hv_viol,
  input logic [DATA_W-1:0] prot_q
);
  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR) |=> (prot_q == $past(bus_wdata)));
  // R3
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == REG_ADDR) |=> (bus_rdata == '0));
  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == REG_ADDR) |=> $stable(prot_q));
  // R6
  unlock_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (&prot_q) |=> !hv_viol);
  // R5
  lock_all_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q == '0 && hv_set_req) |=> hv_viol);
  // R9
  viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
    hv_viol |-> $past(hv_set_req));
  // R9
  viol_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !(hv_viol && $rose(hv_en)));
  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_en) |-> ($past(hv_set_req) && !$past(hv_clr_req)));
  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hv_clr_req |=> !hv_en);
  // R11
  wr_keeps_en_chk: assert property (@(posedge clk) disable iff (rst)
    (hv_en && !hv_clr_req && bus_wr) |=> hv_en);
  // R8
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hv_en) |-> $past(hv_clr_req));
endmodule

bind flash_wp_gate fwp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_addr(op_addr),
  .hv_set_req(hv_set_req), .hv_clr_req(hv_clr_req), .hv_en(hv_en),
  .hv_viol(hv_viol), .prot_q(prot_q)
);

// File: tb/flash_wp_gate_tb.sv
`timescale 1ns/1ps
module flash_wp_gate_tb;
  localparam logic [15:0] RA = 16'hFE09;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, hv_set_req = 0, hv_clr_req = 0;
  logic [15:0] bus_addr = 0, op_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic hv_en, hv_viol;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_reg = 0, m_rd = 0;
  logic m_en = 0, m_viol = 0;

  always #2.5 clk = ~clk;

  flash_wp_gate u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_addr(op_addr),
    .hv_set_req(hv_set_req), .hv_clr_req(hv_clr_req), .hv_en(hv_en), .hv_viol(hv_viol)
  );

  function automatic bit locked_m(input logic [7:0] p, input logic [15:0] a);
    if (p == 8'hFF) return 1'b0;
    return a >= {p[7:1], 9'd0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: update model from pre-edge inputs, compare after the edge
  task automatic step(input string t_rd, input string t_en, input string t_vi);
    logic lk;
    @(posedge clk);
    lk = locked_m(m_reg, op_addr);
    m_viol = hv_set_req && lk;
    if (hv_clr_req) m_en = 0;
    else if (hv_set_req && !lk) m_en = 1;
    m_rd = (bus_rd && bus_addr == RA) ? m_reg : 8'h00;
    if (bus_wr && bus_addr == RA) m_reg = bus_wdata;
    #1;
    chk(t_rd, {8'h0, bus_rdata}, {8'h0, m_rd});
    chk(t_en, {15'h0, hv_en}, {15'h0, m_en});
    chk(t_vi, {15'h0, hv_viol}, {15'h0, m_viol});
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; hv_set_req = 0; hv_clr_req = 0;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    idle(); bus_wr = 1; bus_addr = RA; bus_wdata = v;
    step("R2", "R11", "R9");
    idle();
  endtask

  task automatic try_set(input logic [15:0] a, input string tag);
    idle(); hv_set_req = 1; op_addr = a;
    step("R3", tag, tag);
    idle(); hv_clr_req = 1;
    step("R3", "R10", "R9");
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", {8'h0, bus_rdata}, 16'h0);
    chk("R1", {15'h0, hv_en}, 16'h0);
    chk("R1", {15'h0, hv_viol}, 16'h0);
    idle(); bus_rd = 1; bus_addr = RA;
    step("R1", "R1", "R1");
    // R5 all zeros locks address 0
    try_set(16'h0000, "R5");
    // R2 write and read back with bit 0
    wr_reg(8'h41);
    idle(); bus_rd = 1; bus_addr = RA;
    step("R2", "R8", "R9");
    // R3 read and write elsewhere
    idle(); bus_rd = 1; bus_wr = 1; bus_addr = 16'hFE08; bus_wdata = 8'h77;
    step("R3", "R8", "R9");
    idle(); bus_rd = 1; bus_addr = RA;
    step("R3", "R8", "R9");
    // R4 window boundary at 0x4000 for P=0x41
    try_set(16'h3FFF, "R4");
    try_set(16'h4000, "R4");
    // R7 bit 0 ignored
    wr_reg(8'h40);
    try_set(16'h3FFF, "R7");
    try_set(16'h4000, "R7");
    // R6 unlock code
    wr_reg(8'hFF);
    try_set(16'hFFFF, "R6");
    wr_reg(8'hFE);
    try_set(16'hFFFF, "R4");
    try_set(16'hFDFF, "R4");
    // R11 write during active enable, then new value governs
    wr_reg(8'hFF);
    idle(); hv_set_req = 1; op_addr = 16'h8000;
    step("R3", "R8", "R9");
    wr_reg(8'h00);
    idle(); hv_set_req = 1; op_addr = 16'h8000; bus_wr = 1; bus_addr = RA; bus_wdata = 8'hFF;
    step("R11", "R11", "R11");
    idle(); hv_set_req = 1; hv_clr_req = 1; op_addr = 16'h0000;
    step("R10", "R10", "R9");
    idle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_rd = ($urandom_range(0, 1) == 0);
      bus_addr = ($urandom_range(0, 3) != 0) ? RA : 16'($urandom);
      k = $urandom_range(0, 5);
      bus_wdata = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hFE : 8'($urandom);
      op_addr = ($urandom_range(0, 1) == 0) ? 16'($urandom)
                : ({m_reg[7:1], 9'd0} - 16'($urandom_range(0, 1)));
      hv_set_req = ($urandom_range(0, 1) == 0);
      hv_clr_req = ($urandom_range(0, 4) == 0);
      step("R2", "R8", "R9");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule